// File: doc/BRIEF.md
# Debug memory port lane steering

This block sits between a debugger's byte-oriented memory request and a 32-bit debug access port. One command carries a start address, an item size of 1, 2 or 4 bytes, an item count, an address auto-increment enable and a big-endian quirk enable. For a write, the block takes bytes from a valid/ready input stream and places each one in the correct byte lane of a 32-bit data word. For a read, it picks bytes out of each returned data word and emits them on a valid/ready output stream. Before the first data access, it programs the port's transfer-address register. It programs that register again whenever the port's own address counter cannot be trusted.

Quirk mode handles a class of big-endian targets whose debug port mangles addresses on narrow writes. For quirk-mode writes, the programmed address is XORed with a size-dependent constant, the lanes are permuted, and the address register is reprogrammed after every data write. For quirk-mode reads, the address is used unchanged and the data word is byte-reversed. Quirk mode also refuses misaligned start addresses. Items are always moved one per bus transfer and are never packed.

The controller is a single state machine. `IDLE` accepts a command. On a rejected command it goes to `DONE`, with a count of zero it goes to `DONE`, and otherwise it goes to `TAR`. `TAR` writes the address register and then moves to `GATHER` for a write or `READ` for a read. `GATHER` collects the bytes of one item and then moves to `WRITE`. `WRITE` issues the data write and then goes to `TAR` if a rewrite is needed, to `GATHER` if items remain, or to `DONE`. `READ` fetches one data word and moves to `EMIT`. `EMIT` streams the bytes of that item out and then goes to `TAR` if a rewrite is needed, to `READ` if items remain, or to `DONE`. Any bus error taken in `TAR`, `WRITE` or `READ` leads straight to `DONE`. `DONE` pulses completion for one cycle and returns to `IDLE`.

Top module: `dbg_lane_steer`

## Requirements
- R1: `cmd_size` gives the item size in bytes. Only the values 1, 2 and 4 are legal. Any other value ends the command with `done` and `err_align` high, `bytes_done` at 0, and no bus request.
- R2: In normal mode, the first bus access is an address-register write of `cmd_addr`. Byte k of the stream uses lane (cmd_addr+k) mod 4, and lane L is `bus_wdata[8L+7:8L]`. Lanes that an item does not use are written as zero.
- R3: For a quirk-mode write, the address written to the address register is the byte address XORed with a constant X. X is 0 for size 4, 2 for size 2 and 3 for size 1.
- R4: For a quirk-mode write, a byte at address a goes to lane B XOR (a mod 4) XOR X. B is 3 for size 4, 1 for size 2 and 0 for size 1.
- R5: For a quirk-mode read, the address register receives the unmodified address. A byte at address a is taken from lane 3 − (a mod 4).
- R6: With quirk mode on, a start address that is not a multiple of the size ends the command with `err_align`, for both reads and writes, and no bus request is made.
- R7: With auto-increment on, after a data transfer that leaves items remaining, the next address a is written to the address register before the next data transfer if (a mod BLK) < size. BLK is a power-of-two parameter.
- R8: For a quirk-mode write with X ≠ 0 and auto-increment on, an address-register write of a XOR X precedes every data write after the first.
- R9: With auto-increment off, only one address-register write is made. The byte address used for lane selection still advances by one per byte.
- R10: A bus error response stops the command at once, with no further bus request. `done` and `err_bus` go high, and `bytes_done` holds the bytes of the data transfers that completed before the error.
- R11: A command with count 0 completes with no bus request. `start` is ignored while `busy` is high.
- R12: `bus_op` encodes 0 as an address-register write, 1 as a data write and 2 as a data read. A request keeps its op and write data until `bus_ready` is sampled high.
- R13: The byte streams use valid/ready handshakes. `out_data` holds steady while `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Command strobe, taken while idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_size | input | 3 | Item size in bytes |
| cmd_count | input | CNT_W | Number of items |
| cmd_incr | input | 1 | Port auto-increment enabled |
| cmd_quirk | input | 1 | Big-endian quirk mode |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_align | output | 1 | Command rejected (size or alignment) |
| err_bus | output | 1 | Command stopped by a bus error |
| bytes_done | output | CNT_W+3 | Bytes moved by completed data transfers |
| in_valid | input | 1 | Write byte valid |
| in_data | input | 8 | Write byte |
| in_ready | output | 1 | Write byte accepted |
| out_valid | output | 1 | Read byte valid |
| out_data | output | 8 | Read byte |
| out_ready | input | 1 | Read byte taken |
| bus_req | output | 1 | Bus request |
| bus_op | output | 2 | Bus operation code |
| bus_wdata | output | 32 | Address or data word |
| bus_ready | input | 1 | Bus request completes |
| bus_err | input | 1 | Error response with bus_ready |
| bus_rdata | input | 32 | Read data word with bus_ready |

## Verification
The hardest situation to reach from the ports is an address-register rewrite forced by the auto-increment window. It depends on where the running byte address sits relative to a block boundary after several items. The bench instantiates the block with a 16-byte window and picks start addresses just below a boundary, so that a wrap occurs in the middle of both a write and a read. Bus errors are injected on a chosen handshake index: the address phase, a mid-stream data write and a late data read. The bus, input and output handshakes stall on different cycle patterns, so held requests and held bytes are exercised throughout.

// File: rtl/dls_pkg.sv
package dls_pkg;
    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    typedef enum logic [2:0] {
        S_IDLE, S_TAR, S_GATHER, S_WRITE, S_READ, S_EMIT, S_DONE
    } dls_state_e;

    localparam logic [1:0] OP_TAR = 2'd0;
    localparam logic [1:0] OP_WR  = 2'd1;
    localparam logic [1:0] OP_RD  = 2'd2;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [1:0] quirk_xor(input logic [2:0] sz);
        case (sz)
            3'd2:    return 2'd2;
            3'd1:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] quirk_base(input logic [2:0] sz);
        case (sz)
            3'd4:    return 2'd3;
            3'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/dls_lane_map.sv
module dls_lane_map
    import dls_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [2:0] size,
    input  logic       quirk,
    input  logic       is_wr,
    input  logic [1:0] xor_c,
    output logic [1:0] lane
);
    always_comb begin
        if (!quirk)
            lane = addr_lo;
        else if (is_wr)
            lane = quirk_base(size) ^ addr_lo ^ xor_c;
        else
            lane = 2'd3 - addr_lo;
    end
endmodule

// File: rtl/dls_tar_policy.sv
module dls_tar_policy #(
    parameter int BLK = 1024,
    localparam int BLK_W = $clog2(BLK)
) (
    input  logic [BLK_W-1:0] nxt_off,
    input  logic [2:0]       size,
    input  logic             incr,
    input  logic             xor_nz,
    output logic             need
);
    logic wrap_near;
    assign wrap_near = (32'(nxt_off) < 32'(size));
    assign need      = incr && (xor_nz || wrap_near);
endmodule

// File: rtl/dbg_lane_steer.sv
module dbg_lane_steer
    import dls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BLK    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [2:0]        cmd_size,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_incr,
    input  logic              cmd_quirk,
    output logic              busy,
    output logic              done,
    output logic              err_align,
    output logic              err_bus,
    output logic [CNT_W+2:0]  bytes_done,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic [31:0]       bus_rdata
);
    localparam int BLK_W = $clog2(BLK);
    localparam int BD_W  = CNT_W + 3;

    dls_state_e        state_q, state_d;
    logic              is_wr_q, quirk_q, incr_q;
    logic [2:0]        size_q;
    logic [1:0]        xor_q;
    logic [ADDR_W-1:0] addr_q, tar_q, nxt_addr;
    logic [CNT_W-1:0]  items_q;
    logic [1:0]        nib_q;
    logic [DW-1:0]     word_q, word_upd;
    logic [BD_W-1:0]   bcnt_q;
    logic              ea_q, eb_q;

    logic       accept, cmd_bad, bus_hs, in_hs, out_hs, last_nib, more, need_tar;
    logic [1:0] cmd_xor, lane;

    assign accept  = (state_q == S_IDLE) && start;
    assign cmd_xor = (cmd_quirk && cmd_write) ? quirk_xor(cmd_size) : 2'd0;
    assign cmd_bad = !size_legal(cmd_size) ||
                     (cmd_quirk && |(cmd_addr[1:0] & (cmd_size[1:0] - 2'd1)));
    assign bus_hs   = bus_req && bus_ready;
    assign in_hs    = in_ready && in_valid;
    assign out_hs   = out_valid && out_ready;
    assign last_nib = (nib_q == (size_q[1:0] - 2'd1));
    assign more     = (items_q != CNT_W'(1));
    assign nxt_addr = (state_q == S_EMIT) ? addr_q + ADDR_W'(1) : addr_q;

    dls_lane_map u_lane (
        .addr_lo (addr_q[1:0]),
        .size    (size_q),
        .quirk   (quirk_q),
        .is_wr   (is_wr_q),
        .xor_c   (xor_q),
        .lane    (lane)
    );

    dls_tar_policy #(.BLK(BLK)) u_policy (
        .nxt_off (nxt_addr[BLK_W-1:0]),
        .size    (size_q),
        .incr    (incr_q),
        .xor_nz  (xor_q != 2'd0),
        .need    (need_tar)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_upd[g*8 +: 8] = (lane == 2'(g)) ? in_data : word_q[g*8 +: 8];
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = (cmd_bad || cmd_count == '0) ? S_DONE : S_TAR;
            S_TAR:    if (bus_hs) state_d = bus_err ? S_DONE : (is_wr_q ? S_GATHER : S_READ);
            S_GATHER: if (in_hs && last_nib) state_d = S_WRITE;
            S_WRITE:  if (bus_hs) begin
                          if (bus_err || !more) state_d = S_DONE;
                          else state_d = need_tar ? S_TAR : S_GATHER;
                      end
            S_READ:   if (bus_hs) state_d = bus_err ? S_DONE : S_EMIT;
            S_EMIT:   if (out_hs && last_nib) begin
                          if (!more) state_d = S_DONE;
                          else state_d = need_tar ? S_TAR : S_READ;
                      end
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            is_wr_q <= 1'b0;
            quirk_q <= 1'b0;
            incr_q  <= 1'b0;
            size_q  <= 3'd4;
            xor_q   <= 2'd0;
            addr_q  <= '0;
            tar_q   <= '0;
            items_q <= '0;
            nib_q   <= 2'd0;
            word_q  <= '0;
            bcnt_q  <= '0;
            ea_q    <= 1'b0;
            eb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (start) begin
                    is_wr_q <= cmd_write;
                    quirk_q <= cmd_quirk;
                    incr_q  <= cmd_incr;
                    size_q  <= cmd_size;
                    xor_q   <= cmd_xor;
                    addr_q  <= cmd_addr;
                    tar_q   <= cmd_addr ^ ADDR_W'(cmd_xor);
                    items_q <= cmd_count;
                    nib_q   <= 2'd0;
                    word_q  <= '0;
                    bcnt_q  <= '0;
                    ea_q    <= cmd_bad;
                    eb_q    <= 1'b0;
                end
                S_TAR: if (bus_hs && bus_err) eb_q <= 1'b1;
                S_GATHER: if (in_hs) begin
                    word_q <= word_upd;
                    addr_q <= addr_q + ADDR_W'(1);
                    nib_q  <= nib_q + 2'd1;
                end
                S_WRITE: if (bus_hs) begin
                    if (bus_err) eb_q <= 1'b1;
                    else begin
                        bcnt_q  <= bcnt_q + BD_W'(size_q);
                        items_q <= items_q - CNT_W'(1);
                        tar_q   <= nxt_addr ^ ADDR_W'(xor_q);
                        nib_q   <= 2'd0;
                        word_q  <= '0;
                    end
                end
                S_READ: if (bus_hs) begin
                    if (bus_err) eb_q <= 1'b1;
                    else begin
                        word_q <= bus_rdata;
                        bcnt_q <= bcnt_q + BD_W'(size_q);
                        nib_q  <= 2'd0;
                    end
                end
                S_EMIT: if (out_hs) begin
                    addr_q <= nxt_addr;
                    nib_q  <= nib_q + 2'd1;
                    if (last_nib) begin
                        items_q <= items_q - CNT_W'(1);
                        tar_q   <= nxt_addr ^ ADDR_W'(xor_q);
                        nib_q   <= 2'd0;
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_DONE);
        err_align  = ea_q;
        err_bus    = eb_q;
        bytes_done = bcnt_q;
        in_ready   = (state_q == S_GATHER);
        out_valid  = (state_q == S_EMIT);
        out_data   = word_q[{lane, 3'b000} +: 8];
        bus_req    = 1'b0;
        bus_op     = OP_TAR;
        bus_wdata  = '0;
        unique case (state_q)
            S_TAR:   begin bus_req = 1'b1; bus_op = OP_TAR; bus_wdata = tar_q[31:0]; end
            S_WRITE: begin bus_req = 1'b1; bus_op = OP_WR;  bus_wdata = word_q;      end
            S_READ:  begin bus_req = 1'b1; bus_op = OP_RD;                           end
            default: ;
        endcase
    end

    // R1: an illegal size never reaches the bus
    p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !size_legal(cmd_size) |=> done && err_align && !bus_req);

    // R6: quirk-mode misalignment is refused
    p_align_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_quirk && size_legal(cmd_size) &&
        ((cmd_addr[2:0] & (cmd_size - 3'd1)) != 3'd0) |=> done && err_align);

    // R8: quirk write with nonzero XOR reprograms the address register next
    p_quirk_rewrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hs && !bus_err && bus_op == OP_WR && quirk_q && incr_q &&
        xor_q != 2'd0 && more |=> bus_req && bus_op == OP_TAR);

    // R10: an error response ends bus activity
    p_err_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hs && bus_err |=> done && err_bus && !bus_req);

    // R12: a pending request is held
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_op) && $stable(bus_wdata));

    // R13: a pending output byte is held
    p_out_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/dbg_lane_steer_tb_top.sv
module dbg_lane_steer_tb_top;
    localparam int TB_BLK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, cmd_write = 1'b0, cmd_incr = 1'b0, cmd_quirk = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [2:0]  cmd_size = 3'd4;
    logic [15:0] cmd_count = '0;
    logic        busy, done, err_align, err_bus;
    logic [18:0] bytes_done;
    logic        in_valid = 1'b0, in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        bus_req, bus_ready = 1'b0, bus_err = 1'b0;
    logic [1:0]  bus_op;
    logic [31:0] bus_wdata, bus_rdata = '0;

    always #5 clk = ~clk;

    dbg_lane_steer #(.ADDR_W(32), .CNT_W(16), .BLK(TB_BLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_count(cmd_count),
        .cmd_incr(cmd_incr), .cmd_quirk(cmd_quirk), .busy(busy), .done(done),
        .err_align(err_align), .err_bus(err_bus), .bytes_done(bytes_done),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, nfeed = 0;
    int hs_idx = 0, rd_idx = 0, err_at = -1;
    string tag = "R2";
    logic [1:0]  exp_op[$];
    logic [31:0] exp_dat[$];
    logic [7:0]  exp_out[$];
    logic [7:0]  feed[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rdw(input int i);
        return 32'h3C5A7E91 + (32'(i) * 32'h01020304);
    endfunction

    // bus responder, stream driver and monitor, all at the falling edge
    always @(negedge clk) begin
        logic [1:0]  eo;
        logic [31:0] ed;
        logic [7:0]  eb;
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
        bus_ready = (cyc % 3 != 1);
        bus_err   = 1'b0;
        if (rst_n && bus_req && bus_ready) begin
            if (exp_op.size() == 0) chk(0, {tag, "/R12 unexpected bus request"}, bus_op, 3);
            else begin
                eo = exp_op.pop_front();
                ed = exp_dat.pop_front();
                chk(bus_op == eo && (eo == 2'd2 || bus_wdata == ed), tag,
                    {bus_op, bus_wdata}, {eo, ed});
            end
            if (bus_op == 2'd2) begin bus_rdata = rdw(rd_idx); rd_idx++; end
            if (hs_idx == err_at) bus_err = 1'b1;
            hs_idx++;
        end
        in_valid = (feed.size() > 0) && (cyc % 5 != 3);
        in_data  = (feed.size() > 0) ? feed[0] : 8'h00;
        if (in_valid && in_ready) void'(feed.pop_front());
        out_ready = (cyc % 4 != 2);
        if (rst_n && out_valid && out_ready) begin
            if (exp_out.size() == 0) chk(0, {tag, "/R13 unexpected byte"}, out_data, 0);
            else begin
                eb = exp_out.pop_front();
                chk(out_data == eb, tag, out_data, eb);
            end
        end
    end

    task automatic run_op(input string t, input bit wr, input logic [31:0] addr,
                          input int size, input int count, input bit incr,
                          input bit quirk, input int eat, input bit again);
        int x, base, lane, k, bytes, rdn;
        bit bad, stop;
        logic [31:0] a, w;
        logic [7:0] v;
        tag = t; err_at = eat; hs_idx = 0; rd_idx = 0;
        exp_op.delete(); exp_dat.delete(); exp_out.delete(); feed.delete();
        x    = (quirk && wr) ? (size == 2 ? 2 : (size == 1 ? 3 : 0)) : 0;
        base = (size == 4) ? 3 : ((size == 2) ? 1 : 0);
        bad  = !(size == 1 || size == 2 || size == 4);
        if (!bad && quirk && (addr % size) != 0) bad = 1;
        k = 0; bytes = 0; stop = 0; rdn = 0; a = addr;
        if (!bad && count > 0) begin
            exp_op.push_back(2'd0); exp_dat.push_back(a ^ 32'(x));
            if (k == eat) stop = 1;
            k++;
            for (int i = 0; i < count && !stop; i++) begin
                if (wr) begin
                    w = '0;
                    for (int b = 0; b < size; b++) begin
                        v = 8'(8'h11 + 8'(nfeed * 29)); nfeed++;
                        feed.push_back(v);
                        lane = quirk ? ((base ^ int'(a & 3) ^ x) & 3) : int'(a & 3);
                        w = w | (32'(v) << (8 * lane));
                        a = a + 1;
                    end
                    exp_op.push_back(2'd1); exp_dat.push_back(w);
                end else begin
                    exp_op.push_back(2'd2); exp_dat.push_back('0);
                end
                if (k == eat) stop = 1;
                k++;
                if (!stop) begin
                    bytes += size;
                    if (!wr) begin
                        w = rdw(rdn); rdn++;
                        for (int b = 0; b < size; b++) begin
                            lane = quirk ? (3 - int'(a & 3)) : int'(a & 3);
                            exp_out.push_back(8'(w >> (8 * lane)));
                            a = a + 1;
                        end
                    end
                    if (i < count - 1 && incr && (x != 0 || (a % TB_BLK) < size)) begin
                        exp_op.push_back(2'd0); exp_dat.push_back(a ^ 32'(x));
                        if (k == eat) stop = 1;
                        k++;
                    end
                end
            end
        end
        @(negedge clk);
        start = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_size = 3'(size);
        cmd_count = 16'(count); cmd_incr = incr; cmd_quirk = quirk;
        @(negedge clk);
        start = 1'b0;
        if (again) begin
            @(negedge clk);
            // R11: a second strobe while busy must not disturb the command
            start = 1'b1; cmd_write = ~wr; cmd_addr = 32'hFFF1; cmd_size = 3'd1; cmd_count = 16'd9;
            @(negedge clk);
            start = 1'b0;
        end
        for (int n = 0; n < 3000 && !done; n++) @(negedge clk);
        chk(done, {t, " completion"}, done, 1);
        chk(err_align == bad, {t, " err_align"}, err_align, bad);
        chk(err_bus == stop, {t, " err_bus"}, err_bus, stop);
        chk(bytes_done == 19'(bytes), {t, " bytes_done"}, bytes_done, bytes);
        repeat (4) @(negedge clk);
        chk(exp_op.size() == 0 && exp_out.size() == 0 && feed.size() == 0,
            {t, " all traffic seen"}, exp_op.size() + exp_out.size() + feed.size(), 0);
        feed.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !in_ready && !out_valid && !done, "reset state",
            {busy, bus_req, in_ready, out_valid, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !bus_req, "reset idle", {busy, bus_req}, 0);
        //     tag    wr  addr      sz cnt inc qk  err again
        run_op("R2",  1, 32'h100,  4, 3,  1,  0, -1, 0);
        run_op("R2",  1, 32'h203,  1, 6,  1,  0, -1, 0);
        run_op("R2",  1, 32'h011,  2, 2,  1,  0, -1, 0);
        run_op("R2",  0, 32'h102,  2, 3,  1,  0, -1, 0);
        run_op("R7",  1, 32'h008,  4, 4,  1,  0, -1, 0);
        run_op("R7",  0, 32'h01C,  4, 3,  1,  0, -1, 0);
        run_op("R3",  1, 32'h040,  1, 5,  1,  1, -1, 0);
        run_op("R8",  1, 32'h042,  2, 3,  1,  1, -1, 0);
        run_op("R4",  1, 32'h020,  4, 2,  1,  1, -1, 0);
        run_op("R5",  0, 32'h031,  1, 4,  1,  1, -1, 0);
        run_op("R5",  0, 32'h02C,  4, 2,  1,  1, -1, 0);
        run_op("R6",  1, 32'h041,  2, 2,  1,  1, -1, 0);
        run_op("R6",  0, 32'h042,  4, 1,  1,  1, -1, 0);
        run_op("R1",  1, 32'h040,  3, 2,  1,  0, -1, 0);
        run_op("R1",  0, 32'h040,  0, 2,  1,  0, -1, 0);
        run_op("R1",  1, 32'h040,  7, 1,  1,  1, -1, 0);
        run_op("R9",  1, 32'h007,  1, 5,  0,  0, -1, 0);
        run_op("R9",  1, 32'h004,  1, 3,  0,  1, -1, 0);
        run_op("R10", 1, 32'h100,  4, 4,  1,  0,  2, 0);
        run_op("R10", 0, 32'h040,  1, 5,  1,  1,  0, 0);
        run_op("R10", 0, 32'h200,  2, 4,  1,  0,  3, 0);
        run_op("R11", 1, 32'h080,  4, 0,  1,  0, -1, 0);
        run_op("R11", 1, 32'h060,  4, 3,  1,  0, -1, 1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule